// File: doc/BRIEF.md
# Dependence-Distance Write-Skip Tracker

This block tracks which reorder-buffer slots currently hold an instruction that has been dispatched into the scheduler. It keeps one presence bit per slot, arranged as a circular vector. The oldest live slot is marked by a head pointer and the next free slot by a tail pointer. A dispatch strobe claims the slot at the tail and a retire strobe releases the slot at the head. The pointers wrap modulo the number of slots.

When an instruction issues, the datapath presents its slot index and the 2-bit distance code that the compiler attached to it. The code bounds how far ahead the instruction's last consumer sits. The block looks that many slots ahead of the issuing slot. If the slot there already holds a younger dispatched instruction, every consumer has entered the scheduler and will pick the value off the bypass network. In that case the block raises a combinational skip flag, which lets the datapath drop the reorder-buffer and register-file writes for that result.

Code 00 means the value is visible outside the basic block, so the block always demands the write. The codes for distance 1, distances 2 to 3 and distances 4 to 7 are checked against the upper end of their range, which is 1, 3 or 7 slots ahead. A set bit reached only by wrapping past the tail belongs to an older instruction. Such a bit never grants a skip.

Top module: `dd_skip_tracker`

## Requirements
- R1: A synchronous active-high reset empties the tracker: after reset `empty_o`=1, `full_o`=0, and `skip_o`=0 for any issue.
- R2: Each accepted dispatch claims the slot at the tail; after reset the slots are claimed in order 0, 1, 2, ..., wrapping from DEPTH-1 to 0.
- R3: Each accepted retire releases the oldest occupied slot, at the head, and the head advances by one with wrap; a released slot no longer counts as occupied for issue checks.
- R4: An issue with code 2'b00 (unbounded distance) always gives `skip_o`=0.
- R5: With code 2'b01, 2'b10 or 2'b11, the reach is 1, 3 or 7 slots respectively. `skip_o`=1 exactly when the issuing slot is occupied and the slot at (slot + reach) mod DEPTH holds an instruction younger than it.
- R6: A target slot that is occupied but is reached only by passing the tail, and so holds an older instruction, gives `skip_o`=0; a target reached through the DEPTH-1 to 0 wrap inside the live region still gives `skip_o`=1.
- R7: `full_o`=1 when all DEPTH slots are occupied; a dispatch without a retire while full is ignored.
- R8: `empty_o`=1 when no slot is occupied; a retire while empty is ignored.
- R9: A dispatch and a retire in the same cycle are both applied (also when full; when empty only the dispatch applies), and an issue check in that cycle sees the occupancy from before the update.
- R10: With `iss_vld_i`=0, `skip_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| disp_i | input | 1 | Dispatch strobe: claim the tail slot |
| ret_i | input | 1 | Retire strobe: release the head slot |
| iss_vld_i | input | 1 | An instruction issues this cycle |
| iss_slot_i | input | $clog2(DEPTH) | Slot index of the issuing instruction |
| iss_code_i | input | 2 | Distance code of the issuing instruction |
| skip_o | output | 1 | Result writes may be skipped (combinational) |
| full_o | output | 1 | All slots occupied |
| empty_o | output | 1 | No slot occupied |

## Verification
The assertions assume that the strobes and issue fields are stable around each rising edge. They also assume that the reset is held for at least one edge before any traffic starts. The properties do not assume that the issuing slot is live, because the block must itself refuse a skip for a slot that is free. The stimulus changes inputs only on falling edges and starts after a multi-cycle reset. It deliberately issues from free slots, retires into an empty tracker and dispatches into a full one, so that the guard paths are exercised rather than avoided.

// File: rtl/dd_skip_pkg.sv
package dd_skip_pkg;

   // Compiler-supplied bound on the distance to the last consumer.
   typedef enum logic [1:0] {
      DD_UNBOUNDED = 2'b00,
      DD_ONE       = 2'b01,
      DD_SHORT     = 2'b10,
      DD_MID       = 2'b11
   } dd_code_e;

   localparam int unsigned DD_REACH_W = 3;

   // Upper end of each coded range; zero means "no skip possible".
   function automatic logic [DD_REACH_W-1:0] dd_reach(input logic [1:0] code);
      logic [DD_REACH_W-1:0] r;
      case (dd_code_e'(code))
         DD_ONE:   r = 3'd1;
         DD_SHORT: r = 3'd3;
         DD_MID:   r = 3'd7;
         default:  r = 3'd0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/dd_ptr_ctrl.sv
module dd_ptr_ctrl #(
   parameter int unsigned DEPTH = 128,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             disp_i,
   input  logic             ret_i,
   output logic [PTR_W-1:0] head_o,
   output logic [PTR_W-1:0] tail_o,
   output logic [PTR_W:0]   count_o,
   output logic             disp_ok_o,
   output logic             ret_ok_o,
   output logic             full_o,
   output logic             empty_o
);

   localparam bit              IS_POW2 = (DEPTH == (1 << PTR_W));
   localparam logic [PTR_W-1:0] LAST   = PTR_W'(DEPTH - 1);
   localparam logic [PTR_W:0]   CAP    = (PTR_W+1)'(DEPTH);

   logic [PTR_W-1:0] head_q, tail_q, head_inc, tail_inc;
   logic [PTR_W:0]   count_q;

   generate
      if (IS_POW2) begin : g_pow2_wrap
         assign head_inc = head_q + 1'b1;
         assign tail_inc = tail_q + 1'b1;
      end else begin : g_mod_wrap
         assign head_inc = (head_q == LAST) ? '0 : head_q + 1'b1;
         assign tail_inc = (tail_q == LAST) ? '0 : tail_q + 1'b1;
      end
   endgenerate

   assign full_o    = (count_q == CAP);
   assign empty_o   = (count_q == '0);
   assign ret_ok_o  = ret_i & ~empty_o;
   assign disp_ok_o = disp_i & (~full_o | ret_ok_o);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         head_q  <= '0;
         tail_q  <= '0;
         count_q <= '0;
      end else begin
         if (ret_ok_o)  head_q <= head_inc;
         if (disp_ok_o) tail_q <= tail_inc;
         case ({disp_ok_o, ret_ok_o})
            2'b10:   count_q <= count_q + 1'b1;
            2'b01:   count_q <= count_q - 1'b1;
            default: count_q <= count_q;
         endcase
      end
   end

   assign head_o  = head_q;
   assign tail_o  = tail_q;
   assign count_o = count_q;

endmodule

// File: rtl/dd_presence_vec.sv
module dd_presence_vec #(
   parameter int unsigned DEPTH = 128,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             set_en_i,
   input  logic [PTR_W-1:0] set_idx_i,
   input  logic             clr_en_i,
   input  logic [PTR_W-1:0] clr_idx_i,
   output logic [DEPTH-1:0] pv_o
);

   // One flop per slot; a set on the same slot as a clear wins, which is
   // the full-and-both case where the freed slot is reclaimed at once.
   for (genvar i = 0; i < DEPTH; i++) begin : g_bit
      logic hit_set, hit_clr, bit_q;
      assign hit_set = set_en_i & (set_idx_i == PTR_W'(i));
      assign hit_clr = clr_en_i & (clr_idx_i == PTR_W'(i));
      always_ff @(posedge clk_i) begin
         if (rst_i)        bit_q <= 1'b0;
         else if (hit_set) bit_q <= 1'b1;
         else if (hit_clr) bit_q <= 1'b0;
      end
      assign pv_o[i] = bit_q;
   end

endmodule

// File: rtl/dd_issue_check.sv
module dd_issue_check
   import dd_skip_pkg::*;
#(
   parameter int unsigned DEPTH = 128,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic [DEPTH-1:0] pv_i,
   input  logic [PTR_W-1:0] head_i,
   input  logic [PTR_W:0]   count_i,
   input  logic             vld_i,
   input  logic [PTR_W-1:0] slot_i,
   input  logic [1:0]       code_i,
   output logic             skip_o
);

   localparam logic [PTR_W:0] DEPTH_W = (PTR_W+1)'(DEPTH);

   logic [PTR_W:0]   reach_w, off_w, tgt_sum;
   logic [PTR_W-1:0] tgt_idx;
   logic             in_range, own_bit, far_bit, younger;

   always_comb begin
      reach_w  = (PTR_W+1)'(dd_reach(code_i));
      in_range = ({1'b0, slot_i} < DEPTH_W);
      // age of the issuing slot relative to the head, modulo DEPTH
      if (slot_i >= head_i) off_w = {1'b0, slot_i} - {1'b0, head_i};
      else                  off_w = {1'b0, slot_i} + DEPTH_W - {1'b0, head_i};
      tgt_sum = {1'b0, slot_i} + reach_w;
      tgt_idx = (tgt_sum >= DEPTH_W) ? PTR_W'(tgt_sum - DEPTH_W) : PTR_W'(tgt_sum);
      own_bit = in_range & pv_i[slot_i];
      far_bit = in_range & pv_i[tgt_idx];
      // the target must lie inside the live region, i.e. be younger
      younger = (32'(off_w) + 32'(reach_w)) < 32'(count_i);
      skip_o  = vld_i & (reach_w != '0) & own_bit & far_bit & younger;
   end

endmodule

// File: rtl/dd_skip_tracker.sv
module dd_skip_tracker #(
   parameter int unsigned DEPTH = 128,
   localparam int unsigned PTR_W = $clog2(DEPTH)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             disp_i,
   input  logic             ret_i,
   input  logic             iss_vld_i,
   input  logic [PTR_W-1:0] iss_slot_i,
   input  logic [1:0]       iss_code_i,
   output logic             skip_o,
   output logic             full_o,
   output logic             empty_o
);

   if (DEPTH < 8) begin : g_bad_depth
      $error("dd_skip_tracker: DEPTH must cover the largest reach of 7 plus one");
   end

   logic [PTR_W-1:0] head, tail;
   logic [PTR_W:0]   count;
   logic             disp_ok, ret_ok;
   logic [DEPTH-1:0] pv;

   dd_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .disp_i    (disp_i),
      .ret_i     (ret_i),
      .head_o    (head),
      .tail_o    (tail),
      .count_o   (count),
      .disp_ok_o (disp_ok),
      .ret_ok_o  (ret_ok),
      .full_o    (full_o),
      .empty_o   (empty_o)
   );

   dd_presence_vec #(.DEPTH(DEPTH)) u_pv (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .set_en_i  (disp_ok),
      .set_idx_i (tail),
      .clr_en_i  (ret_ok),
      .clr_idx_i (head),
      .pv_o      (pv)
   );

   dd_issue_check #(.DEPTH(DEPTH)) u_chk_iss (
      .pv_i    (pv),
      .head_i  (head),
      .count_i (count),
      .vld_i   (iss_vld_i),
      .slot_i  (iss_slot_i),
      .code_i  (iss_code_i),
      .skip_o  (skip_o)
   );

endmodule

// File: rtl/dd_skip_tracker_chk.sv
module dd_skip_tracker_chk (
   input logic       clk_i,
   input logic       rst_i,
   input logic       disp_i,
   input logic       ret_i,
   input logic       iss_vld_i,
   input logic [1:0] iss_code_i,
   input logic       skip_o,
   input logic       full_o,
   input logic       empty_o
);

   a_r1_reset_empty: assert property (@(posedge clk_i)
      rst_i |=> (empty_o && !full_o));

   a_r4_unbounded_writes: assert property (@(posedge clk_i) disable iff (rst_i)
      (iss_vld_i && iss_code_i == 2'b00) |-> !skip_o);

   a_r10_idle_no_skip: assert property (@(posedge clk_i) disable iff (rst_i)
      !iss_vld_i |-> !skip_o);

   a_r5_skip_needs_entries: assert property (@(posedge clk_i) disable iff (rst_i)
      skip_o |-> !empty_o);

   a_r7_flags_exclusive: assert property (@(posedge clk_i) disable iff (rst_i)
      !(full_o && empty_o));

   a_r7_full_holds: assert property (@(posedge clk_i) disable iff (rst_i)
      (full_o && disp_i && !ret_i) |=> full_o);

   a_r8_empty_holds: assert property (@(posedge clk_i) disable iff (rst_i)
      (empty_o && ret_i && !disp_i) |=> empty_o);

   a_r2_dispatch_fills: assert property (@(posedge clk_i) disable iff (rst_i)
      (disp_i && !ret_i) |=> !empty_o);

   a_r9_pair_keeps_flags: assert property (@(posedge clk_i) disable iff (rst_i)
      (disp_i && ret_i && !empty_o) |=> ($stable(full_o) && $stable(empty_o)));

endmodule

bind dd_skip_tracker dd_skip_tracker_chk u_sva (
   .clk_i      (clk_i),
   .rst_i      (rst_i),
   .disp_i     (disp_i),
   .ret_i      (ret_i),
   .iss_vld_i  (iss_vld_i),
   .iss_code_i (iss_code_i),
   .skip_o     (skip_o),
   .full_o     (full_o),
   .empty_o    (empty_o)
);

// File: tb/dd_skip_tracker_bench.sv
`timescale 1ns/1ps
module dd_skip_tracker_bench;

   localparam int N  = 16;
   localparam int PW = $clog2(N);

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          disp = 1'b0, ret = 1'b0, vld = 1'b0;
   logic [PW-1:0] slot = '0;
   logic [1:0]    code = 2'b00;
   logic          skip, full, empty;

   always #4 clk = ~clk;   // 125 MHz

   dd_skip_tracker #(.DEPTH(N)) u_dd_skip_tracker (
      .clk_i(clk), .rst_i(rst), .disp_i(disp), .ret_i(ret),
      .iss_vld_i(vld), .iss_slot_i(slot), .iss_code_i(code),
      .skip_o(skip), .full_o(full), .empty_o(empty)
   );

   int total = 0, bad = 0;
   bit done = 0;
   logic [2:0] exp_q[$];
   string      tag_q[$];
   int m_head = 0, m_tail = 0, m_cnt = 0;

   function automatic logic model_skip(bit v, int s, int c);
      int reach, off;
      reach = (c == 1) ? 1 : (c == 2) ? 3 : (c == 3) ? 7 : 0;
      if (!v || reach == 0) return 1'b0;
      off = (s - m_head + N) % N;
      return (off < m_cnt) && (off + reach < m_cnt);
   endfunction

   // driver: apply one cycle of stimulus and queue what the outputs must show
   task automatic step(bit d, bit r, bit v, int s, int c, string tag);
      bit dok, rok;
      @(negedge clk);
      disp = d; ret = r; vld = v; slot = PW'(s); code = 2'(c);
      exp_q.push_back({model_skip(v, s, c), m_cnt == N, m_cnt == 0});
      tag_q.push_back(tag);
      rok = r && (m_cnt > 0);
      dok = d && ((m_cnt < N) || rok);
      if (rok) begin m_head = (m_head + 1) % N; m_cnt--; end
      if (dok) begin m_tail = (m_tail + 1) % N; m_cnt++; end
   endtask

   // monitor: compare between edges
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (exp_q.size() > 0) begin
            logic [2:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            total++;
            if ({skip, full, empty} !== e) begin
               bad++;
               $display("FAIL %s: skip/full/empty got %b expected %b", t, {skip, full, empty}, e);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      // R1: clean state right after reset
      step(0, 0, 1, 0, 1, "R1");
      step(0, 0, 1, 0, 3, "R1");
      // R2: fill slots 0..7 in order while issuing from slot 0
      for (int i = 0; i < 8; i++) step(1, 0, 1, 0, 1, "R2");
      // R5: each code checks its upper reach
      step(0, 0, 1, 0, 3, "R5");
      step(0, 0, 1, 1, 3, "R5");
      step(0, 0, 1, 4, 2, "R5");
      step(0, 0, 1, 5, 2, "R5");
      step(0, 0, 1, 6, 1, "R5");
      step(0, 0, 1, 7, 1, "R5");
      // R4: unbounded code never skips
      step(0, 0, 1, 0, 0, "R4");
      // R10: no issue, no skip
      step(0, 0, 0, 0, 3, "R10");
      // R3: retire the three oldest
      for (int i = 0; i < 3; i++) step(0, 1, 0, 0, 0, "R3");
      step(0, 0, 1, 0, 1, "R3");
      step(0, 0, 1, 3, 1, "R3");
      // R9: paired dispatch/retire, pre-update view then both applied
      step(1, 1, 1, 3, 3, "R9");
      step(0, 0, 1, 4, 1, "R9");
      step(0, 0, 1, 3, 1, "R9");
      step(0, 0, 1, 7, 1, "R9");
      // R7: fill to full, overflow ignored
      for (int i = 0; i < 11; i++) step(1, 0, 0, 0, 0, "R7");
      step(0, 0, 0, 0, 0, "R7");
      step(1, 0, 0, 0, 0, "R7");
      step(0, 0, 1, 4, 3, "R7");
      step(0, 1, 0, 0, 0, "R7");
      step(0, 0, 1, 3, 1, "R7");
      // R6: older bit beyond the tail versus a wrap inside the live region
      step(0, 0, 1, 3, 2, "R6");
      step(0, 0, 1, 2, 3, "R6");
      step(0, 0, 1, 10, 3, "R6");
      // R9: paired strobes while full
      step(1, 0, 0, 0, 0, "R9");
      step(1, 1, 0, 0, 0, "R9");
      step(0, 0, 1, 8, 3, "R9");
      // R8: drain, underflow ignored, then dispatch from empty with retire
      for (int i = 0; i < 16; i++) step(0, 1, 0, 0, 0, "R8");
      step(0, 1, 0, 0, 0, "R8");
      step(1, 1, 1, 0, 1, "R8");
      step(0, 0, 0, 0, 0, "R8");
      // mixed traffic: dispatch-heavy then retire-heavy phases
      for (int i = 0; i < 600; i++) begin
         bit hv;
         hv = ((i / 50) % 2) == 0;
         step($urandom_range(0, 9) < (hv ? 7 : 3), $urandom_range(0, 9) < (hv ? 3 : 7),
              $urandom_range(0, 3) != 0, $urandom_range(0, N-1), $urandom_range(0, 3), "R5");
      end
      step(0, 0, 0, 0, 0, "R10");
      repeat (2) @(negedge clk);
      #3;
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule